// File: doc/BRIEF.md
# Serial Flash Fast-Read Responder

This block is the target side of a serial flash memory that answers the fast-read command on a four-wire serial bus in clock mode 0. The serial clock idles low. While the active-low select is asserted, the host shifts in an opcode, a three-byte start address and one padding byte. The responder then streams stored bytes back, most significant bit first, and moves to the next location after every byte. It keeps on streaming until the host releases select.

The serial pins are oversampled by a faster system clock. Each of them passes through a two-stage synchronizer, and a small control state machine then acts on the detected rising and falling edges of the serial clock. The byte array is filled through a plain synchronous preload port on the system clock. A busy input stands for an erase or program cycle that is running elsewhere. A command that arrives while busy is set is dropped and leaves that cycle untouched. The serial output comes out as a data bit plus an output enable, and the pad drives the line only while the enable is high.

Top module: `spi_fast_read_responder`

## Requirements
- R1: When select is high, sdoOe is low within four system clocks. It stays low for as long as select remains high.
- R2: The only opcode accepted is 0Bh. It is followed by 24 address bits and 8 padding bits, all sampled MSB first on serial clock rising edges. The first data bit is driven on the falling edge that comes right after the last padding bit.
- R3: sdoOe stays low throughout the opcode, address and padding bits.
- R4: Each data byte leaves MSB first. sdoOut changes only after a serial clock falling edge.
- R5: After each byte the location advances by one, so a single command can stream consecutive bytes for as long as the host keeps clocking.
- R6: Only the low MEM_AW address bits pick a location. The upper address bits have no effect on the data returned.
- R7: A command with an opcode other than 0Bh is ignored until select rises: sdoOe never goes high.
- R8: If busy is high when the eighth opcode bit is sampled, the command is ignored. The busy level before or after that point does not matter.
- R9: Raising select at any point, including in the middle of a byte, ends the command. The next command decodes from a clean state.
- R10: A preload write with preWe high stores preData at preAddr. Serial reads that come later return the new value.
- R11: After reset, sdoOe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rstN | input | 1 | Active-low asynchronous reset |
| csN | input | 1 | Active-low select from the host |
| sclk | input | 1 | Serial clock, mode 0 |
| sdi | input | 1 | Serial data from the host |
| sdoOut | output | 1 | Serial data to the host, valid while sdoOe is high |
| sdoOe | output | 1 | Output enable for the serial data pad |
| busy | input | 1 | Set while an erase or program cycle is in progress |
| preWe | input | 1 | Preload write strobe |
| preAddr | input | MEM_AW | Preload byte address |
| preData | input | 8 | Preload byte value |

## Verification
Two events can land in the same system clock cycle: a serial clock falling edge that would shift out or load the next data bit, and select rising, which ends the command. The bench provokes this by pulling sclk low and raising csN at the same instant in the middle of a data byte. Both pins pass through synchronizers of equal depth, so the two events reach the control in the same cycle. The result is judged from two things: sdoOe must drop instead of a new bit appearing, and the very next command must return the correct bytes from its own start address.

// File: rtl/spi_fr_pkg.sv
package spi_fr_pkg;

  typedef enum logic [2:0] {
    PH_CMD,
    PH_ADDR,
    PH_PAD,
    PH_DATA,
    PH_IGNORE
  } phase_t;

  typedef struct packed {
    logic clear;
    logic captureCmd;
    logic captureAddr;
    logic loadByte;
    logic shiftOut;
  } strobes_t;

endpackage

// File: rtl/spi_fr_sync.sv
module spi_fr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic csN,
  input  logic sclk,
  input  logic sdi,
  output logic csHigh,
  output logic riseEvt,
  output logic fallEvt,
  output logic sdiS
);
  logic [STAGES-1:0] csPipe, clkPipe, dinPipe;
  logic clkPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csPipe  <= '1;
      clkPipe <= '0;
      dinPipe <= '0;
      clkPrev <= 1'b0;
    end else begin
      csPipe  <= {csPipe[STAGES-2:0], csN};
      clkPipe <= {clkPipe[STAGES-2:0], sclk};
      dinPipe <= {dinPipe[STAGES-2:0], sdi};
      clkPrev <= clkPipe[STAGES-1];
    end
  end

  assign csHigh  = csPipe[STAGES-1];
  assign sdiS    = dinPipe[STAGES-1];
  assign riseEvt = clkPipe[STAGES-1] & ~clkPrev;
  assign fallEvt = ~clkPipe[STAGES-1] & clkPrev;

endmodule

// File: rtl/spi_fr_ctl.sv
module spi_fr_ctl
  import spi_fr_pkg::*;
#(
  parameter logic [7:0] OPCODE = 8'h0B
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     csHigh,
  input  logic     riseEvt,
  input  logic     fallEvt,
  input  logic     sdiS,
  input  logic     busy,
  input  logic [7:0] cmdShift,
  output strobes_t strobes,
  output logic     oeQ
);
  phase_t      phase;
  logic [4:0]  bitCnt;
  logic [2:0]  outBit;
  logic [7:0]  opcodeNext;

  assign opcodeNext = {cmdShift[6:0], sdiS};

  always_comb begin
    strobes = '0;
    if (csHigh) begin
      strobes.clear = 1'b1;
    end else if (riseEvt) begin
      strobes.captureCmd  = (phase == PH_CMD);
      strobes.captureAddr = (phase == PH_ADDR);
    end else if (fallEvt && phase == PH_DATA) begin
      strobes.loadByte = (outBit == 3'd0);
      strobes.shiftOut = (outBit != 3'd0);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase  <= PH_CMD;
      bitCnt <= '0;
      outBit <= '0;
      oeQ    <= 1'b0;
    end else if (csHigh) begin
      phase  <= PH_CMD;
      bitCnt <= '0;
      outBit <= '0;
      oeQ    <= 1'b0;
    end else if (riseEvt) begin
      case (phase)
        PH_CMD: begin
          if (bitCnt == 5'd7) begin
            bitCnt <= '0;
            phase  <= (opcodeNext == OPCODE && !busy) ? PH_ADDR : PH_IGNORE;
          end else begin
            bitCnt <= bitCnt + 5'd1;
          end
        end
        PH_ADDR: begin
          if (bitCnt == 5'd23) begin
            bitCnt <= '0;
            phase  <= PH_PAD;
          end else begin
            bitCnt <= bitCnt + 5'd1;
          end
        end
        PH_PAD: begin
          if (bitCnt == 5'd7) begin
            bitCnt <= '0;
            phase  <= PH_DATA;
          end else begin
            bitCnt <= bitCnt + 5'd1;
          end
        end
        default: ;
      endcase
    end else if (fallEvt && phase == PH_DATA) begin
      outBit <= outBit + 3'd1;
      oeQ    <= 1'b1;
    end
  end

  // R1: releasing select silences the output on the next cycle
  assert_oe_off_deselected_R1: assert property (@(posedge clk) disable iff (!rstN)
    csHigh |=> !oeQ);

  // R3: no drive before the data phase is reached
  assert_quiet_header_R3: assert property (@(posedge clk) disable iff (!rstN)
    (phase != PH_DATA) |-> !oeQ);

  // R8: busy at the opcode boundary drops the command
  assert_reject_busy_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!csHigh && riseEvt && phase == PH_CMD && bitCnt == 5'd7 && busy) |=> phase == PH_IGNORE);

  // R7: a dropped command stays dropped until select rises
  assert_ignore_sticks_R7: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_IGNORE && !csHigh) |=> phase == PH_IGNORE);

endmodule

// File: rtl/spi_fr_dp.sv
module spi_fr_dp
  import spi_fr_pkg::*;
#(
  parameter int MEM_AW = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strobes,
  input  logic              sdiS,
  input  logic              preWe,
  input  logic [MEM_AW-1:0] preAddr,
  input  logic [7:0]        preData,
  output logic [7:0]        cmdShift,
  output logic              sdoBit
);
  localparam int MEM_DEPTH = 1 << MEM_AW;
  localparam int ADDR_BITS = 24;

  logic [7:0]           mem [MEM_DEPTH];
  logic [ADDR_BITS-1:0] addrReg;
  logic [7:0]           outShift;
  logic [7:0]           rdByte;

  assign rdByte = mem[addrReg[MEM_AW-1:0]];

  always_ff @(posedge clk) begin
    if (preWe) mem[preAddr] <= preData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdShift <= '0;
      addrReg  <= '0;
      outShift <= '0;
      sdoBit   <= 1'b0;
    end else if (strobes.clear) begin
      cmdShift <= '0;
      addrReg  <= '0;
      outShift <= '0;
      sdoBit   <= 1'b0;
    end else begin
      if (strobes.captureCmd)  cmdShift <= {cmdShift[6:0], sdiS};
      if (strobes.captureAddr) addrReg  <= {addrReg[ADDR_BITS-2:0], sdiS};
      if (strobes.loadByte) begin
        sdoBit   <= rdByte[7];
        outShift <= {rdByte[6:0], 1'b0};
        addrReg  <= addrReg + 24'd1;
      end else if (strobes.shiftOut) begin
        sdoBit   <= outShift[7];
        outShift <= {outShift[6:0], 1'b0};
      end
    end
  end

  // R5: each loaded byte moves the pointer forward by one
  assert_addr_advance_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.loadByte && !strobes.clear) |=> addrReg == $past(addrReg) + 24'd1);

  // R10: a preload write lands in the array
  assert_preload_lands_R10: assert property (@(posedge clk) disable iff (!rstN)
    preWe |=> mem[$past(preAddr)] == $past(preData));

endmodule

// File: rtl/spi_fast_read_responder.sv
module spi_fast_read_responder
  import spi_fr_pkg::*;
#(
  parameter int         MEM_AW      = 11,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] OPCODE      = 8'h0B
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sclk,
  input  logic              sdi,
  output logic              sdoOut,
  output logic              sdoOe,
  input  logic              busy,
  input  logic              preWe,
  input  logic [MEM_AW-1:0] preAddr,
  input  logic [7:0]        preData
);
  logic       csHigh, riseEvt, fallEvt, sdiS, sdoBit;
  logic [7:0] cmdShift;
  strobes_t   strobes;

  spi_fr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdi(sdi),
    .csHigh(csHigh), .riseEvt(riseEvt), .fallEvt(fallEvt), .sdiS(sdiS)
  );

  spi_fr_ctl #(.OPCODE(OPCODE)) u_ctl (
    .clk(clk), .rstN(rstN), .csHigh(csHigh), .riseEvt(riseEvt),
    .fallEvt(fallEvt), .sdiS(sdiS), .busy(busy), .cmdShift(cmdShift),
    .strobes(strobes), .oeQ(sdoOe)
  );

  spi_fr_dp #(.MEM_AW(MEM_AW)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .sdiS(sdiS),
    .preWe(preWe), .preAddr(preAddr), .preData(preData),
    .cmdShift(cmdShift), .sdoBit(sdoBit)
  );

  assign sdoOut = sdoOe & sdoBit;

  // R4: the data line holds still unless a falling serial edge was seen
  assert_sdo_on_fall_R4: assert property (@(posedge clk) disable iff (!rstN)
    (sdoOe && !fallEvt && !csHigh) |=> $stable(sdoOut));

endmodule

// File: tb/spi_fast_read_responder_bench.sv
`timescale 1ns/1ps
module spi_fast_read_responder_bench;
  localparam int AW   = 11;
  localparam int HALF = 30;

  logic clk = 1'b0, rstN = 1'b0, csN = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic busy = 1'b0, preWe = 1'b0;
  logic [AW-1:0] preAddr = '0;
  logic [7:0] preData = '0;
  logic sdoOut, sdoOe;

  logic [7:0] model [1<<AW];
  int compared = 0, mismatched = 0;

  always #2.5 clk = ~clk;

  spi_fast_read_responder #(.MEM_AW(AW)) u_spi_fast_read_responder (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdi(sdi),
    .sdoOut(sdoOut), .sdoOe(sdoOe), .busy(busy), .preWe(preWe),
    .preAddr(preAddr), .preData(preData)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] expByte(input logic [23:0] a);
    return model[a[AW-1:0]];
  endfunction

  task automatic preload(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    preWe = 1'b1; preAddr = a; preData = d;
    @(negedge clk);
    preWe = 1'b0;
    model[a] = d;
  endtask

  task automatic sendBit(input logic b, inout int oeSeen);
    sdi = b;
    #HALF;
    if (sdoOe) oeSeen++;
    sclk = 1'b1;
    #HALF;
    sclk = 1'b0;
  endtask

  task automatic header(input logic [7:0] op, input logic [23:0] a,
                        input logic busyOp, input logic busyRest, output int oeSeen);
    oeSeen = 0;
    csN = 1'b0;
    busy = busyOp;
    #HALF;
    for (int i = 7; i >= 0; i--) sendBit(op[i], oeSeen);
    busy = busyRest;
    for (int i = 23; i >= 0; i--) sendBit(a[i], oeSeen);
    for (int i = 7; i >= 0; i--) sendBit(1'b0, oeSeen);
  endtask

  task automatic readByte(output logic [7:0] v, output int oeCnt);
    oeCnt = 0;
    for (int i = 7; i >= 0; i--) begin
      #HALF;
      v[i] = sdoOut;
      if (sdoOe) oeCnt++;
      sclk = 1'b1;
      #HALF;
      sclk = 1'b0;
    end
  endtask

  task automatic endCmd();
    #HALF;
    csN = 1'b1;
    busy = 1'b0;
    #(HALF*2);
  endtask

  task automatic readCheck(input logic [23:0] a, input int n, input string req);
    int oeSeen, oeCnt;
    logic [7:0] v;
    header(8'h0B, a, 1'b0, 1'b0, oeSeen);
    chk({req, " R3 header quiet"}, oeSeen, 0);
    for (int k = 0; k < n; k++) begin
      readByte(v, oeCnt);
      chk({req, " R4 R5 data"}, v, expByte(a + 24'(k)));
      chk({req, " R2 drive"}, oeCnt, 8);
    end
    endCmd();
  endtask

  task automatic ignoredCheck(input logic [7:0] op, input logic busyOp,
                              input logic busyRest, input string req);
    int oeSeen, oeCnt, total;
    logic [7:0] v;
    header(op, 24'h000020, busyOp, busyRest, oeSeen);
    total = oeSeen;
    for (int k = 0; k < 2; k++) begin
      readByte(v, oeCnt);
      total += oeCnt;
    end
    chk({req, " no drive"}, total, 0);
    endCmd();
  endtask

  initial begin
    #750000;
    mismatched++;
    compared++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int oeSeen, oeCnt;
    logic [7:0] v;
    logic [23:0] a;
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    chk("R11 reset oe", sdoOe, 1'b0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    chk("R11 oe after reset", sdoOe, 1'b0);
    chk("R1 idle deselected", sdoOe, 1'b0);

    // R10: fill the array through the preload port
    for (int i = 0; i < (1 << AW); i++) preload(AW'(i), 8'($urandom));

    // R2: directed read from a small address
    readCheck(24'h000010, 3, "R2 directed");
    // R5: stream across many bytes to the top of the array
    readCheck(24'((1 << AW) - 6), 6, "R5 to top");
    // R6: upper address bits do not change the location
    readCheck({8'hA5, 16'(24'h000010)}, 2, "R6 upper bits");

    // R7: foreign opcodes
    ignoredCheck(8'h03, 1'b0, 1'b0, "R7 opcode 03");
    ignoredCheck(8'h0A, 1'b0, 1'b0, "R7 opcode 0A");
    // R8: busy at the opcode boundary rejects; busy later does not
    ignoredCheck(8'h0B, 1'b1, 1'b0, "R8 busy at opcode");
    header(8'h0B, 24'h000040, 1'b0, 1'b1, oeSeen);
    readByte(v, oeCnt);
    chk("R8 busy after opcode accepted", v, expByte(24'h000040));
    endCmd();

    // R9: cut mid-byte, then a clean command
    header(8'h0B, 24'h000100, 1'b0, 1'b0, oeSeen);
    readByte(v, oeCnt);
    for (int i = 0; i < 3; i++) begin
      #HALF; sclk = 1'b1; #HALF; sclk = 1'b0;
    end
    #HALF;
    csN = 1'b1;
    #HALF;
    chk("R9 R1 cut mid byte", sdoOe, 1'b0);
    #HALF;
    readCheck(24'h000200, 2, "R9 after cut");

    // same-cycle: select rises together with a falling serial edge
    header(8'h0B, 24'h000300, 1'b0, 1'b0, oeSeen);
    for (int i = 0; i < 4; i++) begin
      #HALF; sclk = 1'b1; #HALF;
      sclk = 1'b0;
      if (i == 3) csN = 1'b1;
    end
    #HALF;
    chk("R1 R9 cs with falling edge", sdoOe, 1'b0);
    #HALF;
    chk("R1 stays off", sdoOe, 1'b0);
    readCheck(24'h000301, 2, "R9 clean after coincident cut");

    // R10: overwrite and read back
    preload(AW'(5), 8'h3C);
    readCheck(24'h000005, 1, "R10 overwrite");

    // constrained random commands
    for (int n = 0; n < 10; n++) begin
      a = {8'($urandom), 16'($urandom_range(0, (1 << AW) - 5))};
      if ($urandom_range(0, 9) < 7) begin
        readCheck(a, $urandom_range(1, 4), "R5 R6 random read");
      end else begin
        ignoredCheck(8'($urandom_range(12, 255)), 1'b0, 1'b0, "R7 random opcode");
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule